// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block couples two 16-bit buses, A and B, and holds a capture register for each direction of transfer. The bits form two 8-bit lanes. Each lane has its own pair of capture clocks, an active-low drive enable, a direction control and two source selects, so the block serves either as two unrelated byte-wide transceivers or, with the lane controls tied together, as one 16-bit transceiver.

For each lane, the bus chosen by the direction control is driven with either the live value of the opposite bus or the value held in that direction's register. With the enable deasserted, neither bus of the lane is driven, but both registers keep capturing on their clock edges. Each pad is modelled as an input vector, an output vector and a per-bit drive-enable vector, and the pad ring builds the tri-state buffers from these.

Top module: `bus_xcvr_reg`

## Requirements
- R1: The active-low asynchronous reset `rst_n` clears both capture registers to zero. It does not touch the live path: while reset is low, a lane with its select at 0 still passes the opposite bus through.
- R2: On the rising edge of `clk_ab[l]` the lane-l bits of `a_in` are loaded into the A-to-B register. On the rising edge of `clk_ba[l]` the lane-l bits of `b_in` are loaded into the B-to-A register.
- R3: With `oe_n[l]` = 1 (isolation), every lane-l bit of `a_oe` and `b_oe` is 0, and both lane-l registers still capture on their clock edges.
- R4: With `oe_n[l]` = 0, `dir[l]` = 1 sets all lane-l bits of `b_oe` and clears those of `a_oe`. `dir[l]` = 0 does the reverse.
- R5: `sel_ab[l]` = 0 puts the live lane-l bits of `a_in` on `b_out`, and `sel_ab[l]` = 1 puts the stored A-to-B value there. `sel_ba[l]` controls `a_out` from `b_in` and the B-to-A register in the same way. `b_out` and `a_out` carry the selected value whether or not their drive enable is set.
- R6: For every bit position, `a_oe` and `b_oe` are never 1 together.
- R7: Lane 0 is bits [7:0] and lane 1 is bits [15:8]. Control index l acts only on lane l.
- R8: When the live and stored values of an output bit are equal, that bit never changes while the select toggles.
- R9: `b_out` does not depend on `b_in`, and `a_out` does not depend on `a_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous reset of both registers, active low |
| clk_ab | input | LANES | Per-lane capture clock of the A-to-B register |
| clk_ba | input | LANES | Per-lane capture clock of the B-to-A register |
| oe_n | input | LANES | Per-lane drive enable, active low |
| dir | input | LANES | Per-lane direction: 1 drives B, 0 drives A |
| sel_ab | input | LANES | Per-lane source for B: 0 live A, 1 stored |
| sel_ba | input | LANES | Per-lane source for A: 0 live B, 1 stored |
| a_in | input | W | Value seen on the A pads |
| a_out | output | W | Value to drive onto the A pads |
| a_oe | output | W | Per-bit drive enable of the A pads |
| b_in | input | W | Value seen on the B pads |
| b_out | output | W | Value to drive onto the B pads |
| b_oe | output | W | Per-bit drive enable of the B pads |

## Verification
Two functions can meet in one cycle: a register capture while the lane is isolated, and a capture while the same lane is showing stored data. The bench pulses the capture clocks with every one of the sixteen control settings applied to each lane, and it gives the two lanes different settings. A behavioural reference model follows each clock edge. After every cycle the outputs are compared with it, so a capture that leaks through the enable, or that appears on the output a cycle early or late, is reported.

// File: rtl/bus_xcvr_reg.sv
module bus_xcvr_reg #(
  parameter int LANE_W = 8,
  parameter int LANES  = 2,
  localparam int W     = LANE_W * LANES
) (
  input  logic             rst_n,
  input  logic [LANES-1:0] clk_ab,
  input  logic [LANES-1:0] clk_ba,
  input  logic [LANES-1:0] oe_n,
  input  logic [LANES-1:0] dir,
  input  logic [LANES-1:0] sel_ab,
  input  logic [LANES-1:0] sel_ba,
  input  logic [W-1:0]     a_in,
  output logic [W-1:0]     a_out,
  output logic [W-1:0]     a_oe,
  input  logic [W-1:0]     b_in,
  output logic [W-1:0]     b_out,
  output logic [W-1:0]     b_oe
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    localparam int LO = g * LANE_W;
    logic [LANE_W-1:0] ab_q, ba_q, s_ab, s_ba, a_live, b_live;

    assign a_live = a_in[LO +: LANE_W];
    assign b_live = b_in[LO +: LANE_W];

    always_ff @(posedge clk_ab[g] or negedge rst_n)
      if (!rst_n) ab_q <= '0;
      else        ab_q <= a_live;

    always_ff @(posedge clk_ba[g] or negedge rst_n)
      if (!rst_n) ba_q <= '0;
      else        ba_q <= b_live;

    assign s_ab = {LANE_W{sel_ab[g]}};
    assign s_ba = {LANE_W{sel_ba[g]}};

    // consensus term keeps bits with equal sources steady across a select change
    assign b_out[LO +: LANE_W] = (s_ab & ab_q) | (~s_ab & a_live) | (ab_q & a_live);
    assign a_out[LO +: LANE_W] = (s_ba & ba_q) | (~s_ba & b_live) | (ba_q & b_live);

    assign b_oe[LO +: LANE_W] = {LANE_W{~oe_n[g] &  dir[g]}};
    assign a_oe[LO +: LANE_W] = {LANE_W{~oe_n[g] & ~dir[g]}};
  end

endmodule

// File: rtl/bus_xcvr_reg_chk.sv
module bus_xcvr_reg_chk #(
  parameter int LANE_W = 8,
  parameter int W      = 16
) (
  input logic              rst_n,
  input logic              clk0,
  input logic              oe_n0,
  input logic              sel0,
  input logic [LANE_W-1:0] a_in0,
  input logic [LANE_W-1:0] b_out0,
  input logic [W-1:0]      a_oe,
  input logic [W-1:0]      b_oe
);

  logic armed;
  always_ff @(posedge clk0 or negedge rst_n)
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;

  a_r6_no_dual_drive: assert property (@(posedge clk0) disable iff (!rst_n)
    (a_oe & b_oe) == '0);

  a_r3_isolated: assert property (@(posedge clk0) disable iff (!rst_n)
    oe_n0 |-> (a_oe[LANE_W-1:0] == '0) && (b_oe[LANE_W-1:0] == '0));

  a_r4_one_side: assert property (@(posedge clk0) disable iff (!rst_n)
    !oe_n0 |-> ((a_oe[LANE_W-1:0] == '1) != (b_oe[LANE_W-1:0] == '1)));

  a_r2_stored_value: assert property (@(posedge clk0) disable iff (!rst_n)
    (armed && sel0) |-> b_out0 == $past(a_in0));

  a_r5_live_pass: assert property (@(posedge clk0) disable iff (!rst_n)
    !sel0 |-> b_out0 == a_in0);

endmodule

bind bus_xcvr_reg bus_xcvr_reg_chk #(.LANE_W(LANE_W), .W(W)) u_chk (
  .rst_n (rst_n),
  .clk0  (clk_ab[0]),
  .oe_n0 (oe_n[0]),
  .sel0  (sel_ab[0]),
  .a_in0 (a_in[LANE_W-1:0]),
  .b_out0(b_out[LANE_W-1:0]),
  .a_oe  (a_oe),
  .b_oe  (b_oe)
);

// File: tb/sim_bus_xcvr_reg.sv
module sim_bus_xcvr_reg;
  localparam int W = 16;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n;
  logic [1:0] cab, cba, oen, dir, sab, sba;
  logic [W-1:0] ain, bin, a_out, a_oe, b_out, b_oe;
  logic [W-1:0] mab, mba;
  int total = 0, bad = 0, glitch = 0;
  bit live_chk = 0, watch = 0;
  logic [W-1:0] prev, eqmask;

  bus_xcvr_reg u0 (
    .rst_n(rst_n), .clk_ab(cab), .clk_ba(cba), .oe_n(oen), .dir(dir),
    .sel_ab(sab), .sel_ba(sba), .a_in(ain), .a_out(a_out), .a_oe(a_oe),
    .b_in(bin), .b_out(b_out), .b_oe(b_oe)
  );

  task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (live_chk) begin
    logic [W-1:0] eb, ea, ebo, eao;
    for (int l = 0; l < 2; l++) begin
      eb[l*8 +: 8]  = sab[l] ? mab[l*8 +: 8] : ain[l*8 +: 8];
      ea[l*8 +: 8]  = sba[l] ? mba[l*8 +: 8] : bin[l*8 +: 8];
      ebo[l*8 +: 8] = {8{~oen[l] &  dir[l]}};
      eao[l*8 +: 8] = {8{~oen[l] & ~dir[l]}};
    end
    check("R5 b_out", b_out, eb);
    check("R5 a_out", a_out, ea);
    check("R4 b_oe", b_oe, ebo);
    check("R4 a_oe", a_oe, eao);
    check("R6 overlap", a_oe & b_oe, '0);
  end

  always @(b_out) begin
    if (watch && (((b_out ^ prev) & eqmask) != '0)) glitch++;
    prev = b_out;
  end

  task automatic pulse(input logic [1:0] m_ab, input logic [1:0] m_ba);
    @(posedge clk);
    for (int l = 0; l < 2; l++) begin
      if (m_ab[l]) mab[l*8 +: 8] = ain[l*8 +: 8];
      if (m_ba[l]) mba[l*8 +: 8] = bin[l*8 +: 8];
    end
    cab = m_ab; cba = m_ba;
    @(posedge clk);
    cab = '0; cba = '0;
  endtask

  initial begin
    rst_n = 0; cab = 0; cba = 0; oen = 0; dir = 0; sab = 2'b11; sba = 2'b11;
    ain = 16'hA5C3; bin = 16'h3C5A; mab = 0; mba = 0; prev = 0; eqmask = 0;
    repeat (2) @(posedge clk);
    live_chk = 1;
    @(negedge clk);
    check("R1 reset b_out", b_out, 16'h0000);
    check("R1 reset a_out", a_out, 16'h0000);
    @(posedge clk) sab = 2'b00;
    @(negedge clk);
    check("R1 live in reset", b_out, 16'hA5C3);
    @(posedge clk) rst_n = 1;

    for (int c = 0; c < 16; c++) begin
      @(posedge clk);
      {oen[0], dir[0], sab[0], sba[0]} = 4'(c);
      {oen[1], dir[1], sab[1], sba[1]} = 4'(15 - c);
      ain = 16'(c * 16'h1357) ^ 16'h9A0F;
      bin = 16'(c * 16'h2468) ^ 16'h51E3;
      pulse(2'(c), 2'(~c));
      @(posedge clk) ain = ~ain; bin = ~bin;
      @(posedge clk);
    end

    @(posedge clk) oen = 2'b00; dir = 2'b01;
    @(negedge clk);
    check("R4 lane dir b_oe", b_oe, 16'h00FF);
    check("R4 lane dir a_oe", a_oe, 16'hFF00);

    @(posedge clk) oen = 2'b11; sab = 2'b11; sba = 2'b11; ain = 16'hBEEF; bin = 16'hCAFE;
    pulse(2'b01, 2'b01);
    @(negedge clk);
    check("R3 iso a_oe", a_oe, 16'h0000);
    check("R3 iso b_oe", b_oe, 16'h0000);
    @(posedge clk) ain = 0; bin = 0; oen = 2'b00;
    @(negedge clk);
    check("R3 captured B side", {8'h00, b_out[7:0]}, 16'h00EF);
    check("R2 captured A side", {8'h00, a_out[7:0]}, 16'h00FE);

    @(posedge clk) ain = 16'h7700;
    pulse(2'b10, 2'b00);
    @(negedge clk);
    check("R7 lane0 kept", {8'h00, b_out[7:0]}, 16'h00EF);
    check("R7 lane1 loaded", {b_out[15:8], 8'h00}, 16'h7700);

    @(posedge clk) ain = 16'h77E0; sab = 2'b10;
    @(posedge clk) eqmask = 16'h00F0; prev = b_out; watch = 1;
    for (int k = 0; k < 6; k++) @(posedge clk) sab[0] = ~sab[0];
    @(negedge clk) watch = 0;
    check("R8 glitch count", 16'(glitch), 16'h0000);
    check("R8 equal bits", {12'h000, b_out[7:4]}, 16'h000E);

    @(posedge clk) sab = 2'b00; sba = 2'b00; ain = 16'h1234; bin = 16'h5678;
    @(posedge clk) bin = 16'hFFFF;
    @(negedge clk);
    check("R9 b_out ignores b_in", b_out, 16'h1234);
    @(posedge clk) ain = 16'h0000;
    @(negedge clk);
    check("R9 a_out ignores a_in", a_out, 16'hFFFF);

    @(posedge clk) sab = 2'b11; ain = 16'h4321;
    pulse(2'b11, 2'b00);
    @(posedge clk) ain = 16'h0F0F;
    @(negedge clk);
    check("R2 stored A to B", b_out, 16'h4321);

    live_chk = 0;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #800000;
    bad++; total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule